// File: doc/BRIEF.md
# 1-Wire Bit-Slot Timing Engine

This block carries out a single 1-Wire time slot on an open-drain bus line. One slot writes one bit and samples the line exactly once. A slot that reads is the same slot as writing a 1. The controller pulses `start` together with the bit to send and six 16-bit microsecond timing fields. The engine then pulls the line low, lets it go, and takes the line level at a programmed instant. After the remainder of the slot has elapsed, it returns the sampled bit alongside a one-cycle `done` pulse.

The slot is cut into four intervals: a forced-low interval, a pre-sample interval, a post-sample interval and a recovery interval. All four are derived from the timing fields when the slot is accepted. A short sample window sits between the pre-sample and post-sample intervals, and it lasts as many cycles as the input synchronizer has stages. Every interval is counted in microseconds, and one microsecond is `CLKS_PER_US` clock cycles. An interval of zero length is skipped without spending a cycle. Byte framing, bus reset with presence detection, ROM search and CRC sit in the surrounding logic. The two timing fields that belong to the bus reset are accepted at the ports but play no part in a slot.

Top module: `owire_slot_engine`

## Requirements
- R1: The timing set has six 16-bit microsecond fields: bus-reset low time, presence sample time, write-0 low time, write-1 low time, sample time and slot length. The first two have no effect on a slot.
- R2: Sending a 1 (`tx_bit`=1) pulls the line low for the write-1 low time and then releases it. The pre-sample interval lasts (sample time − write-1 low time) and the recovery interval lasts (slot length − sample time). There is no post-sample interval.
- R3: Sending a 0 pulls the line low for the sample time and keeps it low through the sample window. It then holds the line low for (write-0 low time − sample time), releases it, and waits (slot length − write-0 low time).
- R4: `rx_bit` is 1 only when the sampled line level is high, and 0 otherwise.
- R5: An interval of zero microseconds takes no clock cycle at all.
- R6: An interval whose difference would be negative is treated as zero and never wraps.
- R7: The block never drives the line high. `line_pull_low`=1 means pull low and 0 means released.
- R8: Each microsecond of an interval lasts exactly `CLKS_PER_US` clock cycles, counted from the start of that interval.
- R9: `line_in` passes through a `SYNC_STAGES`-flop synchronizer. The captured bit is the line level present at the clock edge that ends the pre-sample interval. A sample window of `SYNC_STAGES` cycles follows that edge, and `rx_bit` changes only when the window ends.
- R10: The bit and the timing fields are latched on the edge that accepts `start`. `start` is ignored while `busy` is high.
- R11: `done` is a one-cycle pulse with the valid `rx_bit` at the end of the slot. `busy` falls in that same cycle. Counting from the accepting edge, the slot takes (sum of the four intervals)×`CLKS_PER_US` + `SYNC_STAGES` cycles.
- R12: After a synchronous reset, `line_pull_low`, `busy`, `done` and `rx_bit` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a slot (taken only when idle) |
| tx_bit | input | 1 | Bit to write; 1 also serves as a read slot |
| t_reset_low | input | 16 | Bus-reset low time in µs (unused by a slot) |
| t_presence_smp | input | 16 | Presence sample time in µs (unused by a slot) |
| t_w0_low | input | 16 | Write-0 low time in µs |
| t_w1_low | input | 16 | Write-1 low time in µs |
| t_sample | input | 16 | Sample instant from slot start in µs |
| t_slot | input | 16 | Total slot length in µs |
| line_in | input | 1 | Level read back from the bus line |
| line_pull_low | output | 1 | 1 pulls the line low, 0 releases it |
| busy | output | 1 | A slot is in progress |
| done | output | 1 | One-cycle end-of-slot pulse |
| rx_bit | output | 1 | Sampled bit, valid with `done` |

## Verification
On every cycle the embedded assertions check the following:
- `done` lasts one cycle and never coincides with `busy`.
- The line is pulled only during a slot.
- A `start` that arrives mid-slot leaves the latched bit and intervals alone.
- A timed interval never runs with a zero count.
- `rx_bit` moves only as a sample window closes.
- The microsecond tick never fires on back-to-back cycles.

Only the bench's sweep can show the exact cycle at which the line is released, the sample instant to the cycle, the negative-difference clamping and the total slot length. The sweep covers every combination of small timing values, both bit values, and a bus level that changes around the sample edge.

// File: rtl/owslot_pkg.sv
package owslot_pkg;

  localparam int TW = 16;

  typedef logic [TW-1:0] us_t;

  // Field order matches the timing set: reset, presence, w0, w1, sample, slot
  typedef struct packed {
    us_t rst_low;
    us_t pres_smp;
    us_t w0_low;
    us_t w1_low;
    us_t smp;
    us_t slot;
  } timing_t;

  typedef struct packed {
    us_t low;
    us_t pre;
    us_t post;
    us_t rec;
  } iv_t;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_LOW  = 3'd1,
    PH_PRE  = 3'd2,
    PH_SMP  = 3'd3,
    PH_POST = 3'd4,
    PH_REC  = 3'd5
  } phase_t;

  // Difference clamped at zero
  function automatic us_t sat_sub(us_t a, us_t b);
    return (a > b) ? us_t'(a - b) : '0;
  endfunction

  // First phase at or after cand that has a nonzero length
  function automatic phase_t skip_empty(phase_t cand, iv_t iv);
    phase_t p;
    p = cand;
    if (p == PH_LOW  && iv.low  == '0) p = PH_PRE;
    if (p == PH_PRE  && iv.pre  == '0) p = PH_SMP;
    if (p == PH_POST && iv.post == '0) p = PH_REC;
    if (p == PH_REC  && iv.rec  == '0) p = PH_IDLE;
    return p;
  endfunction

  function automatic us_t length_of(phase_t p, iv_t iv);
    case (p)
      PH_LOW:  return iv.low;
      PH_PRE:  return iv.pre;
      PH_POST: return iv.post;
      PH_REC:  return iv.rec;
      default: return '0;
    endcase
  endfunction

  // Pull-low enable for each phase; a 1 bit releases after the low phase
  function automatic logic pull_for(phase_t p, logic tx);
    case (p)
      PH_LOW:                    return 1'b1;
      PH_PRE, PH_SMP, PH_POST:   return ~tx;
      default:                   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/owslot_us_tick.sv
module owslot_us_tick #(
  parameter int CLKS_PER_US = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic tick
);
  localparam int CW = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLKS_PER_US - 1);

  logic [CW-1:0] cnt_q;

  assign tick = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || restart)  cnt_q <= '0;
    else if (tick)       cnt_q <= '0;
    else                 cnt_q <= cnt_q + CW'(1);
  end

  // R8: with a divider above one, ticks are never adjacent
  p_tick_gap_r8: assert property (@(posedge clk) disable iff (rst)
    (CLKS_PER_US > 1 && tick) |=> !tick);

endmodule

// File: rtl/owslot_sync.sv
module owslot_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk) begin
    if (rst) q <= '1;   // bus idles high
    else     q <= {q[STAGES-2:0], din};
  end

  assign dout = q[STAGES-1];

endmodule

// File: rtl/owslot_interval_calc.sv
module owslot_interval_calc
  import owslot_pkg::*;
(
  input  timing_t tm,
  input  logic    tx,
  output iv_t     iv
);
  always_comb begin
    if (tx) begin
      iv.low  = tm.w1_low;
      iv.pre  = sat_sub(tm.smp, tm.w1_low);
      iv.post = '0;
      iv.rec  = sat_sub(tm.slot, tm.smp);
    end else begin
      iv.low  = tm.smp;
      iv.pre  = '0;
      iv.post = sat_sub(tm.w0_low, tm.smp);
      iv.rec  = sat_sub(tm.slot, tm.w0_low);
    end
  end

endmodule

// File: rtl/owire_slot_engine.sv
module owire_slot_engine
  import owslot_pkg::*;
#(
  parameter int CLKS_PER_US = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        tx_bit,
  input  logic [15:0] t_reset_low,
  input  logic [15:0] t_presence_smp,
  input  logic [15:0] t_w0_low,
  input  logic [15:0] t_w1_low,
  input  logic [15:0] t_sample,
  input  logic [15:0] t_slot,
  input  logic        line_in,
  output logic        line_pull_low,
  output logic        busy,
  output logic        done,
  output logic        rx_bit
);
  localparam int SCW = $clog2(SYNC_STAGES + 1);
  localparam logic [SCW-1:0] SMP_LAST = SCW'(SYNC_STAGES - 1);

  timing_t tm_in;
  iv_t     iv_in, iv_q, iv_use;
  phase_t  phase_q, phase_n;
  logic    tx_q, tx_use;
  us_t     us_left_q;
  logic [SCW-1:0] smp_cnt_q;
  logic    pull_q, busy_q, done_q, rx_q;
  logic    tick, line_s, phase_end, entering;

  assign tm_in = '{rst_low:  t_reset_low,
                   pres_smp: t_presence_smp,
                   w0_low:   t_w0_low,
                   w1_low:   t_w1_low,
                   smp:      t_sample,
                   slot:     t_slot};

  owslot_interval_calc u_calc (
    .tm (tm_in),
    .tx (tx_bit),
    .iv (iv_in)
  );

  owslot_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (line_in),
    .dout (line_s)
  );

  owslot_us_tick #(.CLKS_PER_US(CLKS_PER_US)) u_tick (
    .clk     (clk),
    .rst     (rst),
    .restart (entering),
    .tick    (tick)
  );

  assign iv_use = (phase_q == PH_IDLE) ? iv_in  : iv_q;
  assign tx_use = (phase_q == PH_IDLE) ? tx_bit : tx_q;

  always_comb begin
    case (phase_q)
      PH_IDLE:                      phase_end = start;
      PH_SMP:                       phase_end = (smp_cnt_q == SMP_LAST);
      PH_LOW, PH_PRE, PH_POST,
      PH_REC:                       phase_end = tick && (us_left_q == us_t'(1));
      default:                      phase_end = 1'b0;
    endcase
  end

  always_comb begin
    phase_n = phase_q;
    if (phase_end) begin
      case (phase_q)
        PH_IDLE: phase_n = skip_empty(PH_LOW, iv_use);
        PH_LOW:  phase_n = skip_empty(PH_PRE, iv_use);
        PH_PRE:  phase_n = PH_SMP;
        PH_SMP:  phase_n = skip_empty(PH_POST, iv_use);
        PH_POST: phase_n = skip_empty(PH_REC, iv_use);
        default: phase_n = PH_IDLE;
      endcase
    end
  end

  assign entering = (phase_n != phase_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q   <= PH_IDLE;
      iv_q      <= '0;
      tx_q      <= 1'b1;
      us_left_q <= '0;
      smp_cnt_q <= '0;
      pull_q    <= 1'b0;
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      rx_q      <= 1'b0;
    end else begin
      phase_q <= phase_n;
      if (phase_q == PH_IDLE && start) begin
        iv_q <= iv_in;
        tx_q <= tx_bit;
      end
      if (entering)                      us_left_q <= length_of(phase_n, iv_use);
      else if (tick && us_left_q != '0)  us_left_q <= us_left_q - us_t'(1);
      if (entering)                      smp_cnt_q <= '0;
      else if (phase_q == PH_SMP)        smp_cnt_q <= smp_cnt_q + SCW'(1);
      if (phase_q == PH_SMP && phase_end) rx_q <= line_s;
      pull_q <= pull_for(phase_n, tx_use);
      busy_q <= (phase_n != PH_IDLE);
      done_q <= (phase_q != PH_IDLE) && (phase_n == PH_IDLE);
    end
  end

  assign line_pull_low = pull_q;
  assign busy          = busy_q;
  assign done          = done_q;
  assign rx_bit        = rx_q;

  // R11: done is a single-cycle pulse
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  // R11: busy has already fallen when done is shown
  p_busy_done_r11: assert property (@(posedge clk) disable iff (rst)
    done_q |-> !busy_q);

  // R7: the line is only ever pulled during a slot
  p_pull_busy_r7: assert property (@(posedge clk) disable iff (rst)
    pull_q |-> busy_q);

  // R10: a start seen mid-slot leaves the latched slot setup alone
  p_latch_r10: assert property (@(posedge clk) disable iff (rst)
    (busy_q && start) |=> ($stable(tx_q) && $stable(iv_q)));

  // R5: a timed phase never runs with a zero count
  p_no_zero_phase_r5: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_LOW || phase_q == PH_PRE || phase_q == PH_POST ||
     phase_q == PH_REC) |-> (us_left_q != '0));

  // R9: the received bit moves only when a sample window closes
  p_rx_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (phase_q != PH_SMP) |=> $stable(rx_q));

endmodule

// File: tb/owire_slot_engine_tb_top.sv
module owire_slot_engine_tb_top;
  localparam int C = 2;
  localparam int S = 2;

  logic        clk = 1'b0;
  logic        rst, start, tx_bit, slave_lvl;
  logic [15:0] t_rst, t_pres, t_w0, t_w1, t_smp, t_slot;
  logic        line_in, pull_low, busy, done, rx_bit;
  int          n_tests = 0;
  int          n_fail  = 0;

  always #5 clk = ~clk;

  // open-drain bus: pulled low by the engine or by a device, else high
  assign line_in = pull_low ? 1'b0 : slave_lvl;

  owire_slot_engine #(.CLKS_PER_US(C), .SYNC_STAGES(S)) dut_i (
    .clk(clk), .rst(rst), .start(start), .tx_bit(tx_bit),
    .t_reset_low(t_rst), .t_presence_smp(t_pres), .t_w0_low(t_w0),
    .t_w1_low(t_w1), .t_sample(t_smp), .t_slot(t_slot),
    .line_in(line_in), .line_pull_low(pull_low), .busy(busy),
    .done(done), .rx_bit(rx_bit)
  );

  function automatic int sat(int a, int b);
    return (a > b) ? a - b : 0;
  endfunction

  // device level per negedge index k; ks is the sample negedge index
  function automatic logic lvl(int pat, int k, int ks);
    case (pat)
      0:       return 1'b1;
      1:       return 1'b0;
      2:       return (k != ks);
      default: return (k == ks);
    endcase
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_slot(int b, int w1, int ms, int w0, int sl, int pat, bit inject);
    int L, P, Q, R, T, D, ks;
    logic exp_rx;
    int bad_pull_k, bad_pull_v, bad_busy_k, bad_busy_v, bad_done_k, bad_done_v;
    L = b ? w1 : ms;
    P = b ? sat(ms, w1) : 0;
    Q = b ? 0 : sat(w0, ms);
    R = b ? sat(sl, ms) : sat(sl, w0);
    T = (L + P + Q + R) * C + S;
    D = b ? L * C : (L + P + Q) * C + S;
    ks = (L + P) * C;
    exp_rx = lvl(pat, ks, ks) && !(ks >= 1 && ks <= D);
    bad_pull_k = -1; bad_busy_k = -1; bad_done_k = -1;
    bad_pull_v = 0;  bad_busy_v = 0;  bad_done_v = 0;

    @(negedge clk);
    tx_bit = b[0];
    t_w1 = 16'(w1); t_smp = 16'(ms); t_w0 = 16'(w0); t_slot = 16'(sl);
    t_rst = 16'hA5A5 ^ 16'(pat * 37 + sl);   // R1: unused fields vary freely
    t_pres = 16'h5A5A ^ 16'(w1 * 11 + ms);
    start = 1'b1;
    slave_lvl = lvl(pat, 0, ks);

    for (int k = 1; k <= T + 2; k++) begin
      @(negedge clk);
      if (k == 1) begin
        // R10: inputs change after acceptance and must not matter
        start = 1'b0;
        tx_bit = ~b[0];
        t_w1 = 16'hFFFF; t_smp = 16'h0007; t_w0 = 16'hFFF0; t_slot = 16'h1234;
      end
      if (inject && k == 2) start = 1'b1;
      if (k == 3) start = 1'b0;
      slave_lvl = lvl(pat, k, ks);
      if (pull_low !== (k <= D) && bad_pull_k < 0) begin
        bad_pull_k = k; bad_pull_v = int'(pull_low);
      end
      if (busy !== (k < T + 1) && bad_busy_k < 0) begin
        bad_busy_k = k; bad_busy_v = int'(busy);
      end
      if (done !== (k == T + 1) && bad_done_k < 0) begin
        bad_done_k = k; bad_done_v = int'(done);
      end
      if (k == T + 1)
        check(rx_bit === exp_rx, "R4 R9 received bit", int'(rx_bit), int'(exp_rx));
    end
    // pull profile covers R2 R3 R5 R6 R7 R8
    check(bad_pull_k < 0, b ? "R2 R5 R6 R7 R8 pull-low profile" : "R3 R5 R6 R7 R8 pull-low profile",
          bad_pull_v, (bad_pull_k >= 0 && bad_pull_k <= D) ? 1 : 0);
    check(bad_busy_k < 0, "R10 R11 busy window", bad_busy_v,
          (bad_busy_k >= 0 && bad_busy_k < T + 1) ? 1 : 0);
    check(bad_done_k < 0, "R11 done pulse", bad_done_v,
          (bad_done_k == T + 1) ? 1 : 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; start = 1'b0; tx_bit = 1'b0; slave_lvl = 1'b1;
    t_rst = '0; t_pres = '0; t_w0 = '0; t_w1 = '0; t_smp = '0; t_slot = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12: outputs after reset
    check(pull_low === 1'b0, "R12 pull after reset", int'(pull_low), 0);
    check(busy === 1'b0,     "R12 busy after reset", int'(busy), 0);
    check(done === 1'b0,     "R12 done after reset", int'(done), 0);
    check(rx_bit === 1'b0,   "R12 rx after reset", int'(rx_bit), 0);

    for (int b = 0; b < 2; b++)
      for (int w1 = 0; w1 < 4; w1++)
        for (int ms = 0; ms < 4; ms++)
          for (int w0 = 0; w0 < 4; w0++)
            for (int sl = 0; sl < 4; sl++)
              for (int pat = 0; pat < 4; pat++)
                run_slot(b, w1, ms, w0, sl, pat, pat[0]);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule